// File: doc/BRIEF.md
# Dual-Component Flash Chip-Select Decoder

This block turns a flash linear address into a request for one of two serial flash components. It picks the component, drives that component's active-low chip select, and gives the address as the component sees it. It also reports whether the access needs a 3-byte or a 4-byte address phase. Component 0 always begins at linear address 0. Component 1 begins right after the last byte of component 0, so the combined space has no gap and one region can cross the boundary.

Each component's density is held in configuration as a power-of-two exponent. Each component also has its own flag that chooses 3-byte or 4-byte addressing. An exponent larger than the chosen addressing can reach is clamped to that addressing's maximum. An address past the end of both components is flagged and selects neither chip.

The decode is registered, with a valid/ready handshake on each side. Its result stays unchanged while the consumer stalls. The serial shifting engine, the command choice and clock generation are outside this block.

Top module: `flash_cs_decode`

## Requirements
- R1: After reset, out_valid is 0 and cs_n is 2'b11, so no chip is selected.
- R2: An address below 2^E0 gives cs_n = 2'b10 (bit 0 low), cs_sel = 0 and local_addr equal to the address. Linear address 0 always decodes this way. E0 is the effective exponent of component 0.
- R3: An address at or above 2^E0 and below 2^E0 + 2^E1 gives cs_n = 2'b01 (bit 1 low), cs_sel = 1 and local_addr equal to the address minus 2^E0.
- R4: An address at or above 2^E0 + 2^E1 sets out_of_range. It also gives cs_n = 2'b11, cs_sel = 0, local_addr = 0 and addr_bytes = 0.
- R5: For an in-range address, addr_bytes is 4 when the selected component's wide flag is 1, and 3 when the flag is 0.
- R6: The effective exponent of a component is its configured exponent capped at 24 with 3-byte addressing, or at 26 with 4-byte addressing. This gives at most 16 MB or 64 MB per component.
- R7: A request accepted on a clock edge (in_valid and in_ready both high) appears on the outputs with out_valid high after that edge. The latency is one cycle.
- R8: While out_valid is 1 and out_ready is 0, in_ready is 0 and every output holds its value.
- R9: When out_ready is 1 and no request is offered, out_valid falls to 0 after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request offered |
| in_addr | input | AW (27) | Linear flash address |
| dens_exp0 | input | EW (5) | Density exponent of component 0 |
| dens_exp1 | input | EW (5) | Density exponent of component 1 |
| wide_addr0 | input | 1 | Component 0 uses 4-byte addressing |
| wide_addr1 | input | 1 | Component 1 uses 4-byte addressing |
| out_ready | input | 1 | Consumer accepts the decode |
| in_ready | output | 1 | Block accepts a request |
| out_valid | output | 1 | Decode result valid |
| cs_n | output | 2 | Active-low chip selects, bit n for component n |
| cs_sel | output | 1 | Index of the selected component |
| local_addr | output | AW (27) | Address within the selected component |
| addr_bytes | output | 3 | Address length in bytes (3 or 4, 0 when out of range) |
| out_of_range | output | 1 | Address lies beyond both components |

## Verification
The bench probes both sides of each boundary: the last byte of component 0, the first byte of component 1, the last byte of component 1 and the first byte past it. A design that is off by one at any of these would select the wrong chip or miss out_of_range. Mixed configurations, such as a 3-byte component 0 with a 4-byte component 1, catch a design that takes the address length from the wrong component. Exponents above the addressing limit check the clamp: without it, the boundary would move and a 16 MB part would wrongly claim addresses beyond 16 MB. A stall with a second request already waiting shows whether the outputs are overwritten early or the waiting request is lost.

// File: rtl/flash_cs_decode.sv
module flash_cs_decode #(
  parameter int AW       = 27,
  parameter int EW       = 5,
  parameter int MAX_EXP3 = 24,
  parameter int MAX_EXP4 = 26
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [AW-1:0] in_addr,
  input  logic [EW-1:0] dens_exp0,
  input  logic [EW-1:0] dens_exp1,
  input  logic          wide_addr0,
  input  logic          wide_addr1,
  input  logic          out_ready,
  output logic          in_ready,
  output logic          out_valid,
  output logic [1:0]    cs_n,
  output logic          cs_sel,
  output logic [AW-1:0] local_addr,
  output logic [2:0]    addr_bytes,
  output logic          out_of_range
);

  localparam logic [EW-1:0] CAP3 = EW'(MAX_EXP3);
  localparam logic [EW-1:0] CAP4 = EW'(MAX_EXP4);

  function automatic logic [EW-1:0] clamp_exp(input logic [EW-1:0] e, input logic wide);
    logic [EW-1:0] cap;
    cap = wide ? CAP4 : CAP3;
    return (e > cap) ? cap : e;
  endfunction

  logic [EW-1:0] e0, e1;
  logic [AW-1:0] base1, off1;
  logic          hit0, hit1, sel_wide;

  assign e0       = clamp_exp(dens_exp0, wide_addr0);
  assign e1       = clamp_exp(dens_exp1, wide_addr1);
  assign base1    = AW'(1) << e0;
  assign off1     = in_addr - base1;
  assign hit0     = (in_addr >> e0) == '0;
  assign hit1     = !hit0 && ((off1 >> e1) == '0);
  assign sel_wide = hit0 ? wide_addr0 : wide_addr1;

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      cs_sel       <= 1'b0;
      local_addr   <= '0;
      addr_bytes   <= 3'd0;
      out_of_range <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_of_range <= !(hit0 || hit1);
        cs_sel       <= hit1;
        local_addr   <= hit0 ? in_addr : (hit1 ? off1 : '0);
        addr_bytes   <= (hit0 || hit1) ? (sel_wide ? 3'd4 : 3'd3) : 3'd0;
      end
    end
  end

  assign cs_n = (out_valid && !out_of_range) ? (cs_sel ? 2'b01 : 2'b10) : 2'b11;

endmodule

module flash_cs_decode_chk #(
  parameter int AW = 27
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_ready,
  input logic          out_valid,
  input logic [1:0]    cs_n,
  input logic          cs_sel,
  input logic [AW-1:0] local_addr,
  input logic [2:0]    addr_bytes,
  input logic          out_of_range
);

  // R1
  idle_no_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> cs_n == 2'b11);

  // R2
  single_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  // R4
  range_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_of_range) |-> (cs_n == 2'b11 && addr_bytes == 3'd0));

  // R5
  addr_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_of_range) |-> (addr_bytes == 3'd3 || addr_bytes == 3'd4));

  // R7
  accept_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(cs_n) && $stable(cs_sel)
      && $stable(local_addr) && $stable(addr_bytes) && $stable(out_of_range)));

  // R8
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R9
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

endmodule

bind flash_cs_decode flash_cs_decode_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_ready(out_ready), .out_valid(out_valid), .cs_n(cs_n), .cs_sel(cs_sel),
  .local_addr(local_addr), .addr_bytes(addr_bytes), .out_of_range(out_of_range)
);

// File: tb/flash_cs_decode_tb.sv
module flash_cs_decode_tb;
  localparam int AW = 27;
  localparam int EW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [AW-1:0] in_addr = '0;
  logic [EW-1:0] dens_exp0 = '0, dens_exp1 = '0;
  logic          wide_addr0 = 1'b0, wide_addr1 = 1'b0;
  logic          out_ready = 1'b1;
  logic          in_ready, out_valid, cs_sel, out_of_range;
  logic [1:0]    cs_n;
  logic [AW-1:0] local_addr;
  logic [2:0]    addr_bytes;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  flash_cs_decode #(.AW(AW), .EW(EW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
    .dens_exp0(dens_exp0), .dens_exp1(dens_exp1),
    .wide_addr0(wide_addr0), .wide_addr1(wide_addr1), .out_ready(out_ready),
    .in_ready(in_ready), .out_valid(out_valid), .cs_n(cs_n), .cs_sel(cs_sel),
    .local_addr(local_addr), .addr_bytes(addr_bytes), .out_of_range(out_of_range)
  );

  function automatic int eff(input int e, input bit wide);
    int cap;
    cap = wide ? 26 : 24;
    return (e > cap) ? cap : e;
  endfunction

  task automatic check(input string req, input bit ok, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_decode(input string req, input longint a);
    longint s0, s1, la;
    bit     wide, oor, sel;
    int     nb;
    logic [1:0] csn;
    s0 = longint'(1) << eff(int'(dens_exp0), wide_addr0);
    s1 = longint'(1) << eff(int'(dens_exp1), wide_addr1);
    if (a < s0) begin
      sel = 0; la = a; wide = wide_addr0; oor = 0; csn = 2'b10;
    end else if (a < s0 + s1) begin
      sel = 1; la = a - s0; wide = wide_addr1; oor = 0; csn = 2'b01;
    end else begin
      sel = 0; la = 0; wide = 0; oor = 1; csn = 2'b11;
    end
    nb = oor ? 0 : (wide ? 4 : 3);
    check(req, out_valid === 1'b1, "out_valid", longint'(out_valid), 1);
    check(req, cs_n === csn, "cs_n", longint'(cs_n), longint'(csn));
    check(req, cs_sel === sel, "cs_sel", longint'(cs_sel), longint'(sel));
    check(req, longint'(local_addr) == la, "local_addr", longint'(local_addr), la);
    check("R5", int'(addr_bytes) == nb, "addr_bytes", longint'(addr_bytes), longint'(nb));
    check(req, out_of_range === oor, "out_of_range", longint'(out_of_range), longint'(oor));
  endtask

  task automatic send(input string req, input longint a);
    @(negedge clk);
    in_addr  = AW'(a);
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check_decode(req, a);
  endtask

  task automatic cfg(input int e0, input bit w0, input int e1, input bit w1);
    @(negedge clk);
    dens_exp0 = EW'(e0); wide_addr0 = w0;
    dens_exp1 = EW'(e1); wide_addr1 = w1;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1", out_valid === 1'b0, "out_valid", longint'(out_valid), 0);
    check("R1", cs_n === 2'b11, "cs_n", longint'(cs_n), 3);
  endtask

  task automatic t_small_parts;
    cfg(20, 0, 20, 0);
    send("R2", 0);
    send("R2", 64'hFFFFF);
    send("R3", 64'h100000);
    send("R3", 64'h1FFFFF);
    send("R4", 64'h200000);
    send("R4", 64'h7FFFFFF);
  endtask

  task automatic t_mixed;
    cfg(24, 0, 26, 1);
    send("R2", 64'hFFFFFF);
    send("R3", 64'h1000000);
    send("R3", 64'h4FFFFFF);
    send("R4", 64'h5000000);
    cfg(22, 1, 21, 0);
    send("R2", 64'h3ABCDE);
    send("R3", 64'h412345);
  endtask

  task automatic t_clamp;
    cfg(31, 0, 20, 0);
    send("R6", 64'hFFFFFF);
    send("R6", 64'h1000000);
    send("R6", 64'h1100000);
    cfg(31, 1, 31, 0);
    send("R6", 64'h1000000);
    send("R6", 64'h4000000);
    send("R6", 64'h5000000);
  endtask

  task automatic t_latency_drain;
    cfg(20, 0, 20, 1);
    @(negedge clk);
    in_addr = AW'(64'h180000); in_valid = 1'b1;
    check("R7", out_valid === 1'b0, "out_valid before edge", longint'(out_valid), 0);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R7", out_valid === 1'b1, "out_valid after edge", longint'(out_valid), 1);
    @(posedge clk);
    @(negedge clk);
    check("R9", out_valid === 1'b0, "out_valid after drain", longint'(out_valid), 0);
    check("R9", cs_n === 2'b11, "cs_n after drain", longint'(cs_n), 3);
  endtask

  task automatic t_stall;
    cfg(20, 0, 20, 0);
    @(negedge clk);
    out_ready = 1'b0;
    send("R8", 64'h0ABCDE);
    in_addr = AW'(64'h150000); in_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk);
      @(negedge clk);
      check("R8", in_ready === 1'b0, "in_ready", longint'(in_ready), 0);
      check_decode("R8", 64'h0ABCDE);
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check_decode("R8", 64'h150000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset;
    @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_small_parts;
    t_mixed;
    t_clamp;
    t_latency_drain;
    t_stall;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule